// File: doc/BRIEF.md
# Decoder-Side Constant Accumulator

This block sits next to an in-order instruction decoder and assembles wide constants from 16-bit pieces. It does not read the register file. It keeps a private accumulator instead.

A full load starts a new constant from a 16-bit immediate plus a separate sign bit. Each partial load shifts the accumulator up by one 16-bit chunk and drops the new immediate into the bottom chunk.

Every constant-load instruction names a destination register. For register 0, the block only updates the accumulator. For any other register, the block issues a one-cycle write request that carries the updated accumulator value. Instructions with any other opcode, and cycles where the decoder presents no valid instruction, leave the accumulator untouched. This lets other work be interleaved inside a constant-building sequence.

Top module: `cacc_top`

## Requirements
- R1: A full load (P bit 0) sets the accumulator to the 17-bit value {S, imm16} sign-extended to 64 bits. With S=0 and imm 0x8000 the result is 0x0000000000008000. With S=1 and imm 0x8000 the result is 0xFFFFFFFFFFFF8000.
- R2: A partial load (P bit 1) sets the accumulator to the old value shifted left by 16, with the immediate in bits 15:0. Bits shifted past bit 63 are lost, and S has no effect.
- R3: A constant load whose destination field is 0 updates the accumulator but raises no write request.
- R4: A constant load to a nonzero destination raises `wrValid` for exactly one cycle, in the cycle after the instruction is accepted. `wrAddr` carries the destination and `wrData` carries the updated accumulator.
- R5: A valid instruction whose opcode differs from `LOAD_OP` leaves the accumulator unchanged and raises no write request.
- R6: While `instValid` is low, the accumulator does not change and no write request is raised, whatever `instWord` holds.
- R7: The instruction word fields are as follows. Opcode is bits 31:24, and the load opcode defaults to 0xA5. P is bit 23, where 1 means partial. S is bit 22. The immediate is bits 21:6. The destination is bits 5:0.
- R8: Synchronous reset clears the accumulator to zero and drives `wrValid`, `wrAddr` and `wrData` to zero.
- R9: Constant loads accepted on consecutive cycles each produce their own write request, on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instValid | input | 1 | Decoder presents an instruction this cycle |
| instWord | input | 32 | Instruction word |
| wrValid | output | 1 | Register write request strobe |
| wrAddr | output | 6 | Destination register of the write |
| wrData | output | 64 | Value to write |

## Verification
The embedded assertions check the following on every cycle:
- a partial load moves the old low 48 bits into the upper bits;
- a full load fills the upper bits with the sign bit;
- idle cycles and foreign opcodes hold the accumulator;
- a write never targets register 0;
- every write follows an accepted instruction;
- reset leaves the outputs at zero.

Only the bench's scenarios can show that whole chained values match the expected constants. The same goes for overflow discarding the top chunk, the S bit being ignored on partial loads, and interleaved or stalled cycles preserving a half-built constant.

// File: rtl/cacc_pkg.sv
package cacc_pkg;

  localparam int OP_W   = 8;
  localparam int IMM_W  = 16;
  localparam int REG_W  = 6;
  localparam int INSN_W = OP_W + 2 + IMM_W + REG_W;

  // Field positions inside the instruction word
  localparam int DEST_LSB = 0;
  localparam int IMM_LSB  = DEST_LSB + REG_W;
  localparam int SIGN_BIT = IMM_LSB + IMM_W;
  localparam int PART_BIT = SIGN_BIT + 1;
  localparam int OP_LSB   = PART_BIT + 1;

  // Strobes and fields handed from control to datapath
  typedef struct packed {
    logic             loadFull;
    logic             loadPart;
    logic             emitWrite;
    logic             signBit;
    logic [IMM_W-1:0] imm;
    logic [REG_W-1:0] dest;
  } cacc_ctrl_t;

endpackage

// File: rtl/cacc_ctrl.sv
module cacc_ctrl
  import cacc_pkg::*;
#(
  parameter logic [OP_W-1:0] LOAD_OP = 8'hA5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instValid,
  input  logic [INSN_W-1:0] instWord,
  output cacc_ctrl_t        ctrl
);

  logic [OP_W-1:0]  opField;
  logic             partField;
  logic             signField;
  logic [IMM_W-1:0] immField;
  logic [REG_W-1:0] destField;
  logic             isLoad;
  logic             destIsZero;

  always_comb begin
    opField    = instWord[OP_LSB +: OP_W];
    partField  = instWord[PART_BIT];
    signField  = instWord[SIGN_BIT];
    immField   = instWord[IMM_LSB +: IMM_W];
    destField  = instWord[DEST_LSB +: REG_W];
    isLoad     = instValid && (opField == LOAD_OP);
    destIsZero = (destField == '0);
  end

  always_comb begin
    ctrl           = '0;
    ctrl.imm       = immField;
    ctrl.dest      = destField;
    ctrl.signBit   = signField;
    ctrl.loadFull  = isLoad && !partField;
    ctrl.loadPart  = isLoad && partField;
    ctrl.emitWrite = isLoad && !destIsZero;
  end

  // R6: with no valid instruction no strobe is raised
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !instValid |-> !(ctrl.loadFull || ctrl.loadPart || ctrl.emitWrite));

  // R2: full and partial loads never fire together
  p_mode_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(ctrl.loadFull && ctrl.loadPart));

endmodule

// File: rtl/cacc_dpath.sv
module cacc_dpath
  import cacc_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  cacc_ctrl_t        ctrl,
  output logic              wrValid,
  output logic [REG_W-1:0]  wrAddr,
  output logic [DATA_W-1:0] wrData
);

  localparam int CHUNKS = DATA_W / IMM_W;
  localparam int UPPER_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] accQ;
  logic [DATA_W-1:0] accNext;

  // One mux per 16-bit lane: full load, partial shift, or hold
  for (genvar g = 0; g < CHUNKS; g++) begin : g_lane
    if (g == 0) begin : g_low
      always_comb begin
        if (ctrl.loadFull || ctrl.loadPart)
          accNext[IMM_W-1:0] = ctrl.imm;
        else
          accNext[IMM_W-1:0] = accQ[IMM_W-1:0];
      end
    end else begin : g_high
      always_comb begin
        if (ctrl.loadFull)
          accNext[g*IMM_W +: IMM_W] = {IMM_W{ctrl.signBit}};
        else if (ctrl.loadPart)
          accNext[g*IMM_W +: IMM_W] = accQ[(g-1)*IMM_W +: IMM_W];
        else
          accNext[g*IMM_W +: IMM_W] = accQ[g*IMM_W +: IMM_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accQ    <= '0;
      wrValid <= 1'b0;
      wrAddr  <= '0;
      wrData  <= '0;
    end else begin
      accQ    <= accNext;
      wrValid <= ctrl.emitWrite;
      if (ctrl.emitWrite) begin
        wrAddr <= ctrl.dest;
        wrData <= accNext;
      end
    end
  end

  // R2: a partial load moves the old low part up one chunk
  p_part_shift_r2: assert property (@(posedge clk) disable iff (rst)
    ctrl.loadPart |=> accQ[DATA_W-1:IMM_W] == $past(accQ[UPPER_W-1:0]));

  // R1: a full load fills everything above the immediate with S
  p_full_fill_r1: assert property (@(posedge clk) disable iff (rst)
    ctrl.loadFull |=> accQ[DATA_W-1:IMM_W] == {UPPER_W{$past(ctrl.signBit)}});

  // R5: the accumulator holds when no load is accepted
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !(ctrl.loadFull || ctrl.loadPart) |=> $stable(accQ));

  // R3: a write never targets register 0
  p_no_r0_write_r3: assert property (@(posedge clk) disable iff (rst)
    wrValid |-> wrAddr != '0);

  // R8: after reset the accumulator and outputs are clear
  p_reset_clear_r8: assert property (@(posedge clk)
    $past(rst) |-> (accQ == '0 && !wrValid && wrData == '0));

endmodule

// File: rtl/cacc_top.sv
module cacc_top
  import cacc_pkg::*;
#(
  parameter int              DATA_W  = 64,
  parameter logic [OP_W-1:0] LOAD_OP = 8'hA5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instValid,
  input  logic [INSN_W-1:0] instWord,
  output logic              wrValid,
  output logic [REG_W-1:0]  wrAddr,
  output logic [DATA_W-1:0] wrData
);

  cacc_ctrl_t ctrlBus;

  cacc_ctrl #(.LOAD_OP(LOAD_OP)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .instValid(instValid),
    .instWord (instWord),
    .ctrl     (ctrlBus)
  );

  cacc_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk    (clk),
    .rst    (rst),
    .ctrl   (ctrlBus),
    .wrValid(wrValid),
    .wrAddr (wrAddr),
    .wrData (wrData)
  );

  // R4: every write follows an accepted instruction one cycle earlier
  p_write_follows_r4: assert property (@(posedge clk) disable iff (rst)
    wrValid |-> $past(instValid));

endmodule

// File: tb/cacc_top_tb.sv
module cacc_top_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instValid = 1'b0;
  logic [31:0] instWord = '0;
  logic        wrValid;
  logic [5:0]  wrAddr;
  logic [63:0] wrData;

  int checks = 0;
  int failures = 0;
  logic [63:0] model = '0;

  localparam logic [7:0] OPC = 8'hA5;

  always #5 clk = ~clk;

  cacc_top u_dut (
    .clk(clk), .rst(rst), .instValid(instValid), .instWord(instWord),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData)
  );

  function automatic logic [31:0] enc(input logic [7:0] op, input logic p,
      input logic s, input logic [15:0] imm, input logic [5:0] dest);
    return {op, p, s, imm, dest};  // R7 layout
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge; returns at the next negedge with outputs settled
  task automatic step(input logic v, input logic [31:0] w);
    instValid = v;
    instWord  = w;
    @(negedge clk);
    instValid = 1'b0;
    instWord  = '0;
  endtask

  task automatic load(input string tag, input logic p, input logic s,
                      input logic [15:0] imm, input logic [5:0] dest);
    if (p) model = {model[47:0], imm};
    else   model = {{47{s}}, s, imm};
    step(1'b1, enc(OPC, p, s, imm, dest));
    check({tag, " wrValid"}, {63'b0, wrValid}, {63'b0, dest != 0});
    if (dest != 0) begin
      check({tag, " wrAddr"}, {58'b0, wrAddr}, {58'b0, dest});
      check({tag, " wrData"}, wrData, model);
    end
  endtask

  task automatic t_reset;
    check("R8 wrValid after reset", {63'b0, wrValid}, 64'd0);
    check("R8 wrData after reset", wrData, 64'd0);
    check("R8 wrAddr after reset", {58'b0, wrAddr}, 64'd0);
    load("R8 partial from cleared acc", 1'b1, 1'b0, 16'h0001, 6'd5);
    check("R8 acc was zero", wrData, 64'h1);
  endtask

  task automatic t_full;
    load("R1 full positive", 1'b0, 1'b0, 16'h7777, 6'd3);
    check("R1 value", wrData, 64'h0000000000007777);
    load("R1 full S=1", 1'b0, 1'b1, 16'h8000, 6'd4);
    check("R1 neg value", wrData, 64'hFFFFFFFFFFFF8000);
    load("R1 full S=0 msb set", 1'b0, 1'b0, 16'h8000, 6'd4);
    check("R1 zero-ext value", wrData, 64'h0000000000008000);
  endtask

  task automatic t_chain_interleave;
    load("R3 full to r0", 1'b0, 1'b0, 16'h7777, 6'd0);
    step(1'b1, enc(8'h12, 1'b0, 1'b0, 16'hFFFF, 6'd9));
    check("R5 foreign opcode no write", {63'b0, wrValid}, 64'd0);
    load("R3 partial to r0", 1'b1, 1'b0, 16'h33bb, 6'd0);
    step(1'b0, enc(OPC, 1'b0, 1'b1, 16'hDEAD, 6'd7));
    check("R6 invalid no write", {63'b0, wrValid}, 64'd0);
    load("R2 chain", 1'b1, 1'b0, 16'h1919, 6'd42);
    check("R2 chained value", wrData, 64'h0000777733bb1919);
    @(negedge clk);
    check("R4 single-cycle pulse", {63'b0, wrValid}, 64'd0);
  endtask

  task automatic t_overflow;
    load("R2 full seed", 1'b0, 1'b1, 16'h0001, 6'd0);
    load("R2 p1", 1'b1, 1'b1, 16'h2222, 6'd0);
    load("R2 p2", 1'b1, 1'b0, 16'h3333, 6'd0);
    load("R2 p3", 1'b1, 1'b1, 16'h4444, 6'd0);
    load("R2 p4 overflow", 1'b1, 1'b1, 16'h5555, 6'd63);
    check("R2 top discarded, S ignored", wrData, 64'h2222333344445555);
  endtask

  task automatic t_back_to_back;
    load("R9 first", 1'b0, 1'b0, 16'hAAAA, 6'd1);
    check("R9 first data", wrData, 64'h000000000000AAAA);
    load("R9 second", 1'b1, 1'b0, 16'hBBBB, 6'd2);
    check("R9 second addr", {58'b0, wrAddr}, 64'd2);
    check("R9 second data", wrData, 64'h00000000AAAABBBB);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_full();
    t_chain_interleave();
    t_overflow();
    t_back_to_back();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule